// File: doc/BRIEF.md
# Drowsy Cache Line Leakage Controller

This block keeps one low-leakage retention flag for each line of a small cache data array. A line whose flag is set sits at a reduced supply voltage. It keeps its contents, but its word line is gated, so it cannot be read or written. Waking the line back to full voltage needs no refill, because nothing was lost.

The block offers two ways to put lines to sleep, chosen by a policy input. In periodic mode, a shared counter sends every line to sleep at once each time a programmable period runs out. In idle-timeout mode, each line has its own 8-bit idle counter, and a line goes to sleep alone once it has gone unaccessed for the programmed number of cycles. A window value of zero turns off automatic sleep in both modes.

Accesses arrive as a strobe with a line index. When the addressed line is asleep, the block raises a stall in the same cycle and wakes the line at the next clock edge. The requester holds its access, which then goes through on the following cycle.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: After synchronous reset every line is awake (`drowsy` all zero), `stall` is low, and all counters start from zero.
- R2: `stall` is high in exactly the cycles in which `acc_valid` is high and the addressed line's flag is set; it is low for an access to an awake line and when no access is presented.
- R3: An access to a sleeping line clears that line's flag at the next clock edge, so the same access repeated in the following cycle completes without a stall.
- R4: An access changes no flag other than that of the line it addresses.
- R5: With `policy`=0 (periodic) and `window`=W>0, the period counter advances on every cycle and wraps after W cycles. At the edge where it wraps, every line is set asleep, except the line accessed in that same cycle, which ends awake.
- R6: With `policy`=1 (idle timeout) and `window`=W>0, an awake line goes to sleep at the clock edge that ends its W-th consecutive cycle without an access. Any access to the line restarts its count from zero.
- R7: Idle counters are 8 bits wide and stop at the window value, so W=255 puts a line to sleep after exactly 255 idle cycles. With `window`=0 no line is ever put to sleep automatically, in either mode.
- R8: Leaving a mode clears its counters. In periodic mode every idle counter is held at zero. In idle-timeout mode the period counter is held at zero, so a new period starts counting from zero on return to periodic mode.
- R9: A sleeping line keeps its flag set until it is accessed (or the block is reset). Neither the passage of time, nor a change of mode, nor a change of window wakes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Line access strobe |
| acc_idx | input | IDXW (3) | Index of the accessed line |
| policy | input | 1 | 0 = periodic sweep, 1 = per-line idle timeout |
| window | input | CNTW (8) | Period or idle window in cycles; 0 disables automatic sleep |
| drowsy | output | LINES (8) | Per-line retention flag, registered |
| stall | output | 1 | Wake-up stall for the current access |

## Verification
The hardest situations to reach are the coincidences: a periodic sweep landing in the same cycle as an access; an idle counter reaching the window in the very cycle its line is accessed; and the window or policy changing while counters are partway through a count. Directed phases line access patterns up with a short period so that sweeps fall on access cycles. A long phase uses a window of 255 to reach the saturation boundary. A long random phase changes the policy and a small window at random while strobing random lines. The bench's reference model is compared against the design on every clock, so each of these coincidences is checked wherever it occurs.

// File: rtl/drowsy_pkg.sv
`timescale 1ns/1ps
package drowsy_pkg;
  typedef enum logic {
    POL_PERIODIC = 1'b0,
    POL_IDLE     = 1'b1
  } policy_e;
endpackage

// File: rtl/drowsy_period_timer.sv
`timescale 1ns/1ps
module drowsy_period_timer #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CNTW-1:0] win,
  output logic            sweep
);
  logic [CNTW-1:0] pcnt_q;
  logic [CNTW:0]   pcnt_inc;

  assign pcnt_inc = {1'b0, pcnt_q} + 1'b1;
  assign sweep    = en && (pcnt_inc >= {1'b0, win});

  always_ff @(posedge clk) begin
    if (rst || !en) pcnt_q <= '0;
    else if (sweep) pcnt_q <= '0;
    else            pcnt_q <= pcnt_inc[CNTW-1:0];
  end

  // R8
  period_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> pcnt_q == '0);
endmodule

// File: rtl/drowsy_line_slot.sv
`timescale 1ns/1ps
module drowsy_line_slot #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit,
  input  logic            sweep,
  input  logic            idle_en,
  input  logic [CNTW-1:0] win,
  output logic            sleep_o
);
  logic            sleep_q;
  logic [CNTW-1:0] idle_q;
  logic [CNTW:0]   idle_inc;
  logic            win_zero;

  assign idle_inc = {1'b0, idle_q} + 1'b1;
  assign win_zero = (win == '0);
  assign sleep_o  = sleep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      idle_q  <= '0;
    end else if (hit) begin
      sleep_q <= 1'b0;
      idle_q  <= '0;
    end else if (sweep) begin
      sleep_q <= 1'b1;
      idle_q  <= '0;
    end else if (!idle_en) begin
      idle_q  <= '0;
    end else if (!win_zero && !sleep_q) begin
      if (idle_inc >= {1'b0, win}) begin
        sleep_q <= 1'b1;
        idle_q  <= win;
      end else begin
        idle_q  <= idle_inc[CNTW-1:0];
      end
    end
  end

  // R3
  wake_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit && sleep_q |=> !sleep_q);

  // R9
  sleep_held_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_q && !hit |=> sleep_q);

  // R7
  no_auto_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    win_zero && !sleep_q |=> !sleep_q);

  // R6
  idle_expire_chk: assert property (@(posedge clk) disable iff (rst)
    idle_en && !hit && !sleep_q && !win_zero && idle_inc >= {1'b0, win} |=> sleep_q);
endmodule

// File: rtl/drowsy_line_ctrl.sv
`timescale 1ns/1ps
module drowsy_line_ctrl
  import drowsy_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CNTW  = 8,
  parameter int IDXW  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDXW-1:0]  acc_idx,
  input  logic             policy,
  input  logic [CNTW-1:0]  window,
  output logic [LINES-1:0] drowsy,
  output logic             stall
);
  policy_e          pol;
  logic             timer_en;
  logic             idle_en;
  logic             sweep;
  logic [LINES-1:0] hit;

  assign pol      = policy_e'(policy);
  assign timer_en = (pol == POL_PERIODIC) && (window != '0);
  assign idle_en  = (pol == POL_IDLE);

  drowsy_period_timer #(.CNTW(CNTW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .en    (timer_en),
    .win   (window),
    .sweep (sweep)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign hit[g] = acc_valid && (acc_idx == IDXW'(g));
    drowsy_line_slot #(.CNTW(CNTW)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[g]),
      .sweep   (sweep),
      .idle_en (idle_en),
      .win     (window),
      .sleep_o (drowsy[g])
    );
  end

  assign stall = acc_valid && drowsy[acc_idx];

  // R1
  reset_awake_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> drowsy == '0);

  // R5
  sweep_all_chk: assert property (@(posedge clk) disable iff (rst)
    sweep |=> $countones(drowsy) >= LINES - 1);

  // R4
  single_wake_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !sweep |=> $countones(drowsy) >= $countones($past(drowsy)) - 1);
endmodule

// File: tb/drowsy_line_ctrl_test.sv
`timescale 1ns/1ps
module drowsy_line_ctrl_test;
  localparam int LINES = 8;
  localparam int CNTW  = 8;
  localparam int IDXW  = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_valid = 1'b0;
  logic [IDXW-1:0]  acc_idx = '0;
  logic             policy = 1'b0;
  logic [CNTW-1:0]  window = '0;
  logic [LINES-1:0] drowsy;
  logic             stall;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  int m_d[LINES];
  int m_c[LINES];
  int m_p;

  always #2.5 clk = ~clk;

  drowsy_line_ctrl #(.LINES(LINES), .CNTW(CNTW)) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .policy(policy), .window(window), .drowsy(drowsy), .stall(stall)
  );

  function automatic logic [LINES-1:0] model_vec();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = (m_d[i] != 0);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < LINES; i++) begin m_d[i] = 0; m_c[i] = 0; end
    m_p = 0;
  endtask

  task automatic model_edge(bit v, int idx, bit pol, int w);
    bit sw;
    sw = (pol == 0) && (w != 0) && (m_p + 1 >= w);
    for (int i = 0; i < LINES; i++) begin
      if (v && i == idx) begin m_d[i] = 0; m_c[i] = 0; end
      else if (sw) begin m_d[i] = 1; m_c[i] = 0; end
      else if (pol == 0) m_c[i] = 0;
      else if (w != 0 && m_d[i] == 0) begin
        if (m_c[i] + 1 >= w) begin m_d[i] = 1; m_c[i] = w; end
        else m_c[i] = m_c[i] + 1;
      end
    end
    if (!((pol == 0) && (w != 0))) m_p = 0;
    else if (sw) m_p = 0;
    else m_p = m_p + 1;
  endtask

  // drive at negedge, compare, then advance the model at the edge
  task automatic step(bit v, int idx);
    int exp_stall;
    acc_valid = v;
    acc_idx   = IDXW'(idx);
    #1;
    exp_stall = (v && m_d[idx] != 0) ? 1 : 0;
    check({tag, " drowsy"}, int'(drowsy), int'(model_vec()));
    check({tag, " stall"}, int'(stall), exp_stall);
    @(posedge clk);
    model_edge(v, idx, policy, int'(window));
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    check("R1 drowsy after reset", int'(drowsy), 0);
    check("R1 stall after reset", int'(stall), 0);
    idle(1);

    // R5: periodic sweep with window 4, all asleep after 4 edges
    tag = "R5";
    policy = 1'b0; window = 8'd4;
    model_reset(); // counters at zero: timer disabled while window was 0
    idle(3);
    check("R5 not yet swept", int'(drowsy), 0);
    idle(1);
    check("R5 all asleep", int'(drowsy), 8'hFF);

    // R2/R3/R4: wake with window 0 so nothing re-sleeps (R7)
    tag = "R2";
    window = 8'd0;
    acc_valid = 1; acc_idx = 3; #1;
    check("R2 stall on sleeping line", int'(stall), 1);
    @(negedge clk);
    model_edge(1, 3, 0, 0);
    acc_idx = 3; #1;
    check("R3 no stall after wake", int'(stall), 0);
    check("R4 only line 3 woken", int'(drowsy), 8'hF7);
    tag = "R3";
    step(1, 3);
    tag = "R7";
    idle(30);
    check("R7 window 0 keeps line 3 awake", int'(drowsy), 8'hF7);
    tag = "R9";
    policy = 1'b1; idle(5); policy = 1'b0; idle(5);
    check("R9 sleeping lines stay asleep", int'(drowsy), 8'hF7);

    // R6: idle timeout, window 5
    tag = "R6";
    policy = 1'b1; window = 8'd5;
    step(1, 1); step(1, 2);
    for (int k = 0; k < 20; k++) step(k % 3 == 0, 0);
    check("R6 line 0 refreshed stays awake", int'(drowsy[0]), 0);
    check("R6 lines 1,2 timed out", int'(drowsy[2:1]), 3);
    step(1, 4); idle(4);
    check("R6 line 4 awake after 4 idle", int'(drowsy[4]), 0);
    idle(1);
    check("R6 line 4 asleep after 5 idle", int'(drowsy[4]), 1);

    // R8: mode switch clears counters
    tag = "R8";
    step(1, 5); idle(3);
    policy = 1'b0; window = 8'd0; idle(2);
    policy = 1'b1; window = 8'd5; idle(4);
    check("R8 idle count restarted", int'(drowsy[5]), 0);
    idle(1);
    check("R8 line 5 asleep", int'(drowsy[5]), 1);

    // R5: sweep coinciding with an access spares that line
    tag = "R5";
    policy = 1'b0; window = 8'd3;
    for (int k = 0; k < 24; k++) step(1, k % LINES);

    // R7: saturation boundary at 255
    tag = "R7";
    policy = 1'b1; window = 8'd255;
    step(1, 6); idle(254);
    check("R7 awake after 254 idle", int'(drowsy[6]), 0);
    idle(1);
    check("R7 asleep after 255 idle", int'(drowsy[6]), 1);

    // mixed random traffic
    tag = "R2 R4 R5 R6 R8 random";
    for (int k = 0; k < 3000; k++) begin
      if (k % 97 == 0) begin
        policy = 1'($urandom_range(0, 1));
        window = CNTW'($urandom_range(0, 9));
      end
      step(($urandom_range(0, 3) == 0), $urandom_range(0, LINES - 1));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule